// File: doc/BRIEF.md
# One-Time-Programmable Memory Burn Sequencer

This block programs a one-time-programmable byte array from a source image. It walks the addresses from zero up to a last address. At each address it applies fixed-width program pulses, and it reads the byte back after every pulse. An address that verifies moves the walk forward. An address that still reads wrong after a bounded number of pulses stops the run with a failure.

After the last address has been programmed, the block drops the programming supply back to the normal level. It then reads the whole array once more and compares each byte with the image. A single mismatch fails the part. A clean pass marks it good.

The block drives a memory port with an address, write data, a pulse request and a read/write line, and it takes read data back. The read path is combinational. The image is fetched through a source port that shares the memory address. Pulse width is counted in clock cycles derived from the clock rate in kHz.

Top module: `otp_burn_seq`

## Requirements
- R1: After reset, `busy`, `passed`, `failed`, `mem_prog` and `vpp_hi` are all low.
- R2: A `start` pulse while idle does four things on the next cycle: it raises `busy` and `vpp_hi`, sets `mem_addr` to 0, and clears `passed` and `failed`.
- R3: Each program pulse holds `mem_prog` high for exactly CLK_KHZ cycles, which is 1 ms. During a pulse, `mem_rw` is 0 and `mem_wdata` equals `src_data`. Outside pulses, `mem_rw` is 1, which means a read.
- R4: In the cycle after each pulse, the byte at `mem_addr` is compared with `src_data`. On a match the address advances by one and the attempt count starts again from zero. Each address therefore gets up to MAX_TRIES pulses of its own.
- R5: An address that still mismatches after MAX_TRIES pulses sets `failed`, drops `busy` and `vpp_hi`, and issues no further pulses.
- R6: Once LAST_ADDR verifies, `vpp_hi` goes low and every address from 0 to LAST_ADDR is read and compared at normal supply. Any mismatch sets `failed`. A full match sets `passed`.
- R7: `busy` stays high from the start until the outcome. When `busy` falls, exactly one of `passed` and `failed` is high, and it stays high until the next start.
- R8: A `start` pulse while `busy` is high has no effect on the run, its pulse count or its outcome.
- R9: `mem_prog` is never high while `vpp_hi` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a burn run (one-cycle strobe) |
| src_addr | output | ADDR_W | Image address, equal to `mem_addr` |
| src_data | input | DATA_W | Image byte at `src_addr` |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Data to program |
| mem_prog | output | 1 | Program pulse request |
| mem_rw | output | 1 | 1 = read, 0 = program |
| mem_rdata | input | DATA_W | Memory read data, valid in the same cycle |
| vpp_hi | output | 1 | 1 = programming supply, 0 = normal supply |
| busy | output | 1 | Run in progress |
| passed | output | 1 | Last run succeeded |
| failed | output | 1 | Last run failed |

## Verification
The assertions assume two things about the inputs. First, `mem_rdata` and `src_data` are combinational functions of the address and the current supply mode, so the compare in the verify cycle sees the effect of the pulse that just ended. Second, `start` is a single-cycle strobe. The bench meets both assumptions with a memory model that changes its cell contents only at the falling edge of a pulse. It drives `start` for one cycle from the falling clock edge. Cells that need a chosen number of pulses, and read-back corruption that appears only at normal supply, steer each run toward a known pulse total and a known outcome.

// File: rtl/otp_burn_seq.sv
module otp_burn_seq #(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 8,
  parameter int LAST_ADDR = 4095,
  parameter int CLK_KHZ   = 50000,
  parameter int MAX_TRIES = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [ADDR_W-1:0] src_addr,
  input  logic [DATA_W-1:0] src_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_prog,
  output logic              mem_rw,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              vpp_hi,
  output logic              busy,
  output logic              passed,
  output logic              failed
);
  localparam int PULSE_CYC = CLK_KHZ;
  localparam int CNT_W = $clog2(PULSE_CYC + 1);
  localparam int TRY_W = $clog2(MAX_TRIES + 1);
  localparam logic [CNT_W-1:0]  CNT_END  = CNT_W'(PULSE_CYC - 1);
  localparam logic [TRY_W-1:0]  TRY_END  = TRY_W'(MAX_TRIES);
  localparam logic [ADDR_W-1:0] ADDR_END = ADDR_W'(LAST_ADDR);

  typedef enum logic [1:0] {S_IDLE, S_PULSE, S_VERIFY, S_CHECK} state_t;

  state_t            state;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0]  cnt;
  logic [TRY_W-1:0]  tries;
  logic              match;

  assign match     = (mem_rdata == src_data);
  assign mem_addr  = addr;
  assign src_addr  = addr;
  assign mem_wdata = src_data;
  assign mem_prog  = (state == S_PULSE);
  assign mem_rw    = (state != S_PULSE);
  assign busy      = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      addr   <= '0;
      cnt    <= '0;
      tries  <= '0;
      vpp_hi <= 1'b0;
      passed <= 1'b0;
      failed <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state  <= S_PULSE;
          addr   <= '0;
          cnt    <= '0;
          tries  <= '0;
          vpp_hi <= 1'b1;
          passed <= 1'b0;
          failed <= 1'b0;
        end
        S_PULSE: if (cnt == CNT_END) begin
          cnt   <= '0;
          tries <= tries + 1'b1;
          state <= S_VERIFY;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_VERIFY: if (match) begin
          tries <= '0;
          if (addr == ADDR_END) begin
            addr   <= '0;
            vpp_hi <= 1'b0;
            state  <= S_CHECK;
          end else begin
            addr  <= addr + 1'b1;
            state <= S_PULSE;
          end
        end else if (tries == TRY_END) begin
          failed <= 1'b1;
          vpp_hi <= 1'b0;
          state  <= S_IDLE;
        end else begin
          state <= S_PULSE;
        end
        S_CHECK: if (!match) begin
          failed <= 1'b1;
          state  <= S_IDLE;
        end else if (addr == ADDR_END) begin
          passed <= 1'b1;
          state  <= S_IDLE;
        end else begin
          addr <= addr + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [CNT_W:0]    pw_run;
  logic [TRY_W:0]    per_addr;
  logic              prog_d;
  logic [ADDR_W-1:0] addr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pw_run   <= '0;
      per_addr <= '0;
      prog_d   <= 1'b0;
      addr_d   <= '0;
    end else begin
      pw_run <= mem_prog ? pw_run + 1'b1 : '0;
      prog_d <= mem_prog;
      addr_d <= mem_addr;
      if (!busy || mem_addr != addr_d) per_addr <= '0;
      else if (prog_d && !mem_prog)    per_addr <= per_addr + 1'b1;
    end
  end

  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_prog) |-> pw_run == (CNT_W+1)'(PULSE_CYC));

  // R3
  pulse_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pw_run <= (CNT_W+1)'(PULSE_CYC));

  // R5
  tries_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_addr <= (TRY_W+1)'(MAX_TRIES));

  // R7
  outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(passed && failed));

  // R7
  outcome_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (passed || failed));

  // R9
  prog_needs_vpp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_prog |-> vpp_hi);

  // R6
  idle_supply_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !vpp_hi);
endmodule

// File: tb/otp_burn_seq_test.sv
module otp_burn_seq_test;
  localparam int AW = 4, DW = 8, LAST = 11, KHZ = 8, TRIES = 10;

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] src_addr, mem_addr;
  logic [DW-1:0] src_data, mem_wdata, mem_rdata;
  logic mem_prog, mem_rw, vpp_hi, busy, passed, failed;

  logic [DW-1:0] img [0:15];
  logic [DW-1:0] cells [0:15];
  logic [DW-1:0] flip [0:15];
  int need [0:15];
  int pcount [0:15];

  int checks = 0, fails = 0, done_cnt = 0, pulses = 0, hc = 0;
  bit width_bad = 0, wr_bad = 0, vpp_bad = 0, busy_d = 0, over = 0;
  int q_pass [$];
  int q_pulses [$];
  string q_tag [$];

  always #10 clk = ~clk;

  assign src_data  = img[src_addr];
  assign mem_rdata = cells[mem_addr] ^ (vpp_hi ? '0 : flip[mem_addr]);

  otp_burn_seq #(.ADDR_W(AW), .DATA_W(DW), .LAST_ADDR(LAST), .CLK_KHZ(KHZ),
                 .MAX_TRIES(TRIES)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr),
    .src_data(src_data), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_prog(mem_prog), .mem_rw(mem_rw), .mem_rdata(mem_rdata),
    .vpp_hi(vpp_hi), .busy(busy), .passed(passed), .failed(failed));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Memory model and monitor, both on the falling edge
  always @(negedge clk) begin
    if (mem_prog) begin
      hc++;
      if (mem_rw !== 1'b0 || mem_wdata !== img[mem_addr]) wr_bad = 1;
      if (!vpp_hi) vpp_bad = 1;
    end else if (hc > 0) begin
      if (hc != KHZ) width_bad = 1;
      pulses++;
      pcount[mem_addr]++;
      if (pcount[mem_addr] >= need[mem_addr]) cells[mem_addr] = img[mem_addr];
      hc = 0;
    end
    if (busy_d && !busy) begin
      int ep, en;
      string t;
      bit img_ok;
      ep = q_pass.pop_front();
      en = q_pulses.pop_front();
      t  = q_tag.pop_front();
      chk(passed == ep && failed == !ep, {"R6/R5 outcome ", t}, {passed, failed}, ep ? 2 : 1);
      chk(pulses == en, {"R4/R5 pulse total ", t}, pulses, en);
      chk(!width_bad && !wr_bad, {"R3 pulse shape ", t}, {width_bad, wr_bad}, 0);
      chk(!vpp_bad && !vpp_hi, {"R9 supply ", t}, {vpp_bad, vpp_hi}, 0);
      if (ep) begin
        img_ok = 1;
        for (int i = 0; i <= LAST; i++) if (cells[i] != img[i]) img_ok = 0;
        chk(img_ok, {"R6 image burned ", t}, img_ok, 1);
      end
      done_cnt++;
    end
    busy_d = busy;
  end

  task automatic prep();
    for (int i = 0; i < 16; i++) begin
      cells[i] = 8'hFF; pcount[i] = 0; need[i] = 1; flip[i] = 0;
    end
    pulses = 0; width_bad = 0; wr_bad = 0; vpp_bad = 0;
  endtask

  task automatic run_case(input bit exp_pass, input int exp_pulses, input string tag,
                          input bit poke);
    int d;
    d = done_cnt;
    q_pass.push_back(exp_pass);
    q_pulses.push_back(exp_pulses);
    q_tag.push_back(tag);
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk(busy && vpp_hi && mem_addr == 0 && !passed && !failed, {"R2 start ", tag},
        {busy, vpp_hi, passed, failed}, 4'b1100);
    if (poke) begin
      repeat (30) @(negedge clk);
      start = 1; @(negedge clk) start = 0;
      repeat (40) @(negedge clk);
      start = 1; @(negedge clk) start = 0;
    end
    while (done_cnt == d) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) img[i] = DW'(8'h3C ^ (i * 37));
    prep();
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !passed && !failed && !mem_prog && !vpp_hi, "R1 reset", busy, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !vpp_hi, "R1 idle after reset", busy, 0);

    prep();
    run_case(1, 12, "single pulses", 0);

    prep();
    for (int i = 0; i <= LAST; i++) need[i] = (i % 10) + 1;
    run_case(1, 58, "mixed tries", 0);

    prep();
    need[5] = 11;
    run_case(0, 15, "R5 exhausted at addr 5", 0);
    repeat (20) @(negedge clk);
    chk(!busy && failed && !mem_prog, "R5 stopped after exhaustion", busy, 0);

    prep();
    need[0] = 10; need[1] = 10;
    run_case(1, 30, "R4 count restarts", 0);

    prep();
    flip[LAST] = 8'h01;
    run_case(0, 12, "R6 final compare mismatch", 0);

    prep();
    flip[0] = 8'h80;
    run_case(0, 12, "R6 mismatch at first addr", 0);

    prep();
    run_case(1, 12, "R8 start while busy", 1);
    repeat (20) @(negedge clk);
    // R7 R8
    chk(!busy && passed && !failed, "R7/R8 outcome held, no rerun", {busy, passed, failed}, 3'b010);

    over = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!over) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", done_cnt, -1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule